// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block decides when a CAN node is cut off from the bus and when it may return. The error-confinement logic raises a one-cycle trigger when the node has to go bus-off. The block then raises the bus-off status and the error status, forces the software reset-request bit high, and turns off the transmit driver so that the pin floats. The node stays cut off until software writes the reset-request bit low.

After that write, the block counts bus-free indications. The bus-idle detector outside the block gives one pulse for each run of eleven recessive bits. When the programmed number of these pulses has arrived (128 by default), the block clears both status bits and turns the driver back on. In the same step it sends a single-cycle clear pulse to the transmit and receive error counters. If software raises reset-request again during the count, or the node is forced off the bus again, the count stops and recovery starts over. Software can set or clear reset-request freely while the node is bus-on.

Top module: `canbo_recovery`

## Requirements
- R1: While reset is asserted, and after it is released, the block is bus-on. The reset-request, error-status and counter-clear outputs are 0, the driver enable is 1, and the bus-free count is zero.
- R2: A bus-off trigger sampled at a clock edge sets bus_off_o, rrq_o and err_stat_o to 1 in the following cycle. It does this from any state.
- R3: While bus-off, rrq_o stays 1 until software writes the value 0. A write of 1 while waiting for software has no effect.
- R4: Bus-free pulses are not counted while reset-request is high. A pulse in the same cycle as the clearing write is not counted either, so exactly 127 later pulses leave the node bus-off.
- R5: The pulse that makes 128 counted bus-free pulses (RECOV_EVENTS) after the clearing write brings the node back. In the next cycle bus_off_o is 0, err_stat_o is 0 and tx_drv_en_o is 1.
- R6: ecnt_clr_o is 1 for exactly one cycle, and only in the first cycle after a completed recovery.
- R7: A software write of 1 to reset-request during the count sets rrq_o to 1 and discards the count. The next recovery again needs a clearing write followed by 128 pulses. This abort takes priority over a completing pulse in the same cycle.
- R8: A bus-off trigger during the count restarts the sequence from waiting for software, with the count at zero.
- R9: tx_drv_en_o is 0 in every cycle in which bus_off_o is 1, and 1 otherwise.
- R10: While bus-on, a software write sets rrq_o to the written value in the next cycle, and bus_off_o stays 0.
- R11: A bus-off trigger takes priority over a completing bus-free pulse in the same cycle: the node stays bus-off and no counter clear is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| busoff_evt_i | input | 1 | One-cycle bus-off trigger from error confinement |
| rrq_wr_i | input | 1 | Software write strobe for the reset-request bit |
| rrq_wdata_i | input | 1 | Value written to reset-request |
| bus_free_i | input | 1 | One-cycle pulse per detected bus-free interval |
| bus_off_o | output | 1 | Bus status: 1 means bus-off |
| rrq_o | output | 1 | Reset-request bit |
| err_stat_o | output | 1 | Error status: 1 means errors present |
| ecnt_clr_o | output | 1 | Single-cycle clear for both error counters |
| tx_drv_en_o | output | 1 | Transmit output driver enable |

## Verification
A wrong internal count shows up only at the end of a recovery. The node comes back one or more pulses early or late, so the bench checks the 127th and 128th pulse after each clearing write, plus the aborted and restarted cases. A wrong sequencer state shows up one cycle after the stimulus that exposes it, as a wrong reset-request, status or driver value. A cycle-by-cycle reference model compares all five outputs in every cycle of directed and random traffic.

// File: rtl/canbo_pkg.sv
`timescale 1ns/1ps
package canbo_pkg;
  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_WAIT = 2'd1,
    ST_CNT  = 2'd2
  } canbo_state_e;
endpackage

// File: rtl/canbo_freecnt.sv
`timescale 1ns/1ps
module canbo_freecnt #(
  parameter int LIMIT = 128,
  parameter int CW    = $clog2(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          keep_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // enable: load when counting advances or when the count must be cleared
  assign cnt_en = (run_i && tick_i) || !keep_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!keep_i)
      cnt_d = '0;
    else if (run_i && tick_i)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign hit_o = run_i && tick_i && (cnt_q == LAST);

  p_hold_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && keep_i && !tick_i) |=> (cnt_q == $past(cnt_q)));

  p_clear_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_i |=> (cnt_q == '0));
endmodule

// File: rtl/canbo_seq.sv
`timescale 1ns/1ps
module canbo_seq
  import canbo_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busoff_evt_i,
  input  logic         wr_en_i,
  input  logic         wr_val_i,
  input  logic         hit_i,
  output canbo_state_e state_o,
  output logic         keep_o,
  output logic         rrq_o,
  output logic         err_o,
  output logic         clr_o
);
  canbo_state_e state_q, state_d;
  logic         rrq_q, rrq_d;
  logic         err_q, err_d;
  logic         clr_q, clr_d;

  always_comb begin
    state_d = state_q;
    rrq_d   = rrq_q;
    err_d   = err_q;
    clr_d   = 1'b0;
    if (busoff_evt_i) begin
      state_d = ST_WAIT;
      rrq_d   = 1'b1;
      err_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_ON: begin
          if (wr_en_i) rrq_d = wr_val_i;
        end
        ST_WAIT: begin
          if (wr_en_i && !wr_val_i) begin
            state_d = ST_CNT;
            rrq_d   = 1'b0;
          end
        end
        ST_CNT: begin
          if (wr_en_i && wr_val_i) begin
            state_d = ST_WAIT;
            rrq_d   = 1'b1;
          end else if (hit_i) begin
            state_d = ST_ON;
            err_d   = 1'b0;
            clr_d   = 1'b1;
          end
        end
        default: state_d = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      rrq_q   <= 1'b0;
      err_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rrq_q   <= rrq_d;
      err_q   <= err_d;
      clr_q   <= clr_d;
    end
  end

  assign state_o = state_q;
  assign keep_o  = (state_d == ST_CNT);
  assign rrq_o   = rrq_q;
  assign err_o   = err_q;
  assign clr_o   = clr_q;

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt_i |=> (state_q == ST_WAIT && rrq_q && err_q));

  p_rrq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ON && rrq_q && !busoff_evt_i && !(wr_en_i && !wr_val_i)) |=> rrq_q);

  p_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && $past(state_q) == ST_CNT) |-> (clr_q && !err_q));

  p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CNT && wr_en_i && wr_val_i && !busoff_evt_i) |=> (state_q == ST_WAIT && rrq_q && !clr_q));
endmodule

// File: rtl/canbo_recovery.sv
`timescale 1ns/1ps
module canbo_recovery
  import canbo_pkg::*;
#(
  parameter int RECOV_EVENTS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_evt_i,
  input  logic rrq_wr_i,
  input  logic rrq_wdata_i,
  input  logic bus_free_i,
  output logic bus_off_o,
  output logic rrq_o,
  output logic err_stat_o,
  output logic ecnt_clr_o,
  output logic tx_drv_en_o
);
  localparam int CNT_W = $clog2(RECOV_EVENTS);

  canbo_state_e   state;
  logic           keep_cnt;
  logic           hit;
  logic [CNT_W-1:0] free_cnt;

  canbo_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .busoff_evt_i (busoff_evt_i),
    .wr_en_i      (rrq_wr_i),
    .wr_val_i     (rrq_wdata_i),
    .hit_i        (hit),
    .state_o      (state),
    .keep_o       (keep_cnt),
    .rrq_o        (rrq_o),
    .err_o        (err_stat_o),
    .clr_o        (ecnt_clr_o)
  );

  canbo_freecnt #(
    .LIMIT (RECOV_EVENTS),
    .CW    (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state == ST_CNT),
    .keep_i (keep_cnt),
    .tick_i (bus_free_i),
    .cnt_o  (free_cnt),
    .hit_o  (hit)
  );

  assign bus_off_o   = (state != ST_ON);
  assign tx_drv_en_o = (state == ST_ON);

  p_cnt_zero_rrq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rrq_o |-> (free_cnt == '0));

  p_clr_on_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_clr_o |-> (!bus_off_o && !err_stat_o));
endmodule

// File: tb/canbo_recovery_bench.sv
`timescale 1ns/1ps
module canbo_recovery_bench;
  localparam int N = 128;

  logic clk;
  logic rst_n;
  logic busoff_evt_i, rrq_wr_i, rrq_wdata_i, bus_free_i;
  logic bus_off_o, rrq_o, err_stat_o, ecnt_clr_o, tx_drv_en_o;

  int n_chk;
  int n_fail;
  bit done;

  bit m_off, m_rrq, m_err, m_clr;
  int m_cnt;

  canbo_recovery #(.RECOV_EVENTS(N)) u_canbo_recovery (
    .clk(clk), .rst_n(rst_n),
    .busoff_evt_i(busoff_evt_i), .rrq_wr_i(rrq_wr_i),
    .rrq_wdata_i(rrq_wdata_i), .bus_free_i(bus_free_i),
    .bus_off_o(bus_off_o), .rrq_o(rrq_o), .err_stat_o(err_stat_o),
    .ecnt_clr_o(ecnt_clr_o), .tx_drv_en_o(tx_drv_en_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void model_reset();
    m_off = 0; m_rrq = 0; m_err = 0; m_clr = 0; m_cnt = 0;
  endfunction

  function automatic void model_step(bit evt, bit wr, bit wd, bit tk);
    m_clr = 0;
    if (evt) begin
      m_off = 1; m_rrq = 1; m_err = 1; m_cnt = 0;
    end else if (!m_off) begin
      if (wr) m_rrq = wd;
    end else if (m_rrq) begin
      if (wr && !wd) begin m_rrq = 0; m_cnt = 0; end
    end else begin
      if (wr && wd) begin
        m_rrq = 1; m_cnt = 0;
      end else if (tk) begin
        if (m_cnt == N - 1) begin
          m_off = 0; m_err = 0; m_cnt = 0; m_clr = 1;
        end else m_cnt = m_cnt + 1;
      end
    end
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "bus_off", bus_off_o, m_off);
    check(req, "rrq", rrq_o, m_rrq);
    check(req, "err_stat", err_stat_o, m_err);
    check(req, "ecnt_clr", ecnt_clr_o, m_clr);
    check("R9", "tx_drv_en", tx_drv_en_o, !m_off);
  endtask

  task automatic cyc(input bit evt, input bit wr, input bit wd, input bit tk, input string req);
    busoff_evt_i = evt; rrq_wr_i = wr; rrq_wdata_i = wd; bus_free_i = tk;
    @(posedge clk); #1;
    busoff_evt_i = 0; rrq_wr_i = 0; rrq_wdata_i = 0; bus_free_i = 0;
    model_step(evt, wr, wd, tk);
    compare_all(req);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, req);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0;
    busoff_evt_i = 0; rrq_wr_i = 0; rrq_wdata_i = 0; bus_free_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    rst_n = 1;
    @(posedge clk); #1;
    compare_all("R1");

    // R10: bus-on writes
    cyc(0, 1, 1, 0, "R10");
    check("R10", "rrq set", rrq_o, 1'b1);
    cyc(0, 1, 0, 1, "R10");
    check("R10", "bus_off stays", bus_off_o, 1'b0);

    // R2: entry
    cyc(1, 0, 0, 0, "R2");
    check("R2", "bus_off", bus_off_o, 1'b1);
    check("R9", "drv off", tx_drv_en_o, 1'b0);

    // R3: held, pulses ignored, write 1 no effect
    ticks(5, "R3");
    cyc(0, 1, 1, 1, "R3");
    check("R3", "rrq held", rrq_o, 1'b1);

    // R4: clearing write with a pulse not counted, then 127
    cyc(0, 1, 0, 1, "R4");
    ticks(N - 1, "R4");
    check("R4", "still off after 127", bus_off_o, 1'b1);
    cyc(0, 0, 0, 1, "R5");
    check("R5", "back on", bus_off_o, 1'b0);
    check("R6", "clr pulse", ecnt_clr_o, 1'b1);
    cyc(0, 0, 0, 1, "R6");
    check("R6", "clr single", ecnt_clr_o, 1'b0);

    // R7: abort during count
    cyc(1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, "R7");
    ticks(60, "R7");
    cyc(0, 1, 1, 0, "R7");
    check("R7", "rrq back", rrq_o, 1'b1);
    cyc(0, 1, 0, 0, "R7");
    ticks(N - 1, "R7");
    check("R7", "count restarted", bus_off_o, 1'b1);
    ticks(1, "R7");
    check("R7", "recovered", bus_off_o, 1'b0);
    // abort on the completing pulse
    cyc(1, 0, 0, 0, "R7");
    cyc(0, 1, 0, 0, "R7");
    ticks(N - 1, "R7");
    cyc(0, 1, 1, 1, "R7");
    check("R7", "abort wins", bus_off_o, 1'b1);

    // R8: re-entry during count
    cyc(0, 1, 0, 0, "R8");
    ticks(100, "R8");
    cyc(1, 0, 0, 1, "R8");
    check("R8", "rrq forced", rrq_o, 1'b1);
    cyc(0, 1, 0, 0, "R8");
    ticks(N - 1, "R8");
    check("R8", "fresh count", bus_off_o, 1'b1);
    ticks(1, "R8");

    // R11: trigger beats completing pulse
    cyc(1, 0, 0, 0, "R11");
    cyc(0, 1, 0, 0, "R11");
    ticks(N - 1, "R11");
    cyc(1, 0, 0, 1, "R11");
    check("R11", "stays off", bus_off_o, 1'b1);
    check("R11", "no clr", ecnt_clr_o, 1'b0);

    // random traffic, fixed seed
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 30000; i++) begin
      bit e, w, d, t;
      e = (($urandom % 400) == 0);
      w = (($urandom % 150) == 0);
      d = $urandom % 2;
      t = (($urandom % 4) != 0);
      cyc(e, w, d, t, "R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule